// File: doc/BRIEF.md
# Validation Coprocessor with Timed Interrupts

This block is a test coprocessor. It answers two coprocessor numbers, called A and B, and both numbers see one shared bank of sixteen data registers. The core transfers values between its own registers and the bank with move commands on either number. Number A also serves memory load and store beats. Both numbers accept data-operation commands. These commands turn register contents into timed effects: a busy-wait of a programmed length, delayed assertion of an active-low fast or normal interrupt line, clearing of either line, and capture of a free-running cycle counter into the bank.

The core presents a command with `cmd_valid` high, and raises `cmd_first` in the first cycle of that command. It then keeps presenting the same command until the block answers done. The two-bit response is combinational from the command inputs and the internal state. Side effects (register writes, counter loads, line changes) take effect at the next rising clock edge. The core's instruction decode and its exception handling are not part of this block. The interrupt lines are plain outputs for the core's interrupt inputs.

Top module: `tcop_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all sixteen bank registers and the cycle counter to zero, and drives `fiq_n` and `irq_n` high.
- R2: Move commands use instruction bits 19:16 as the register index and work on both numbers. Kind 1 writes `wr_data` into the bank. Kind 0 returns the register on `rd_data` in the same cycle and answers done. A value written through one number reads back through the other.
- R3: Load (kind 2) and store (kind 3) use instruction bits 15:12 as the index and are accepted only on number A. A load beat writes `wr_data` and a store beat returns the register on `rd_data`. On number B both kinds are rejected and the bank is unchanged.
- R4: When instruction bit 22 is set, a load or store is long. Beats 0 to LONG_BEATS-2 (counted from the `cmd_first` beat) answer next-word and the final beat answers done. A short transfer answers done on its first beat.
- R5: The opcode of a data operation is instruction bits 23:20. Number A accepts only opcode 0 and number B accepts opcodes 0 to 5. Several other commands are also rejected: other opcodes, command kinds 5 to 7, and any coprocessor number other than A or B. A rejected command has no effect.
- R6: Opcode 0 reads a delay D from the register indexed by instruction bits 3:0. With D = 0 the first cycle answers done. Otherwise the first cycle and the next D-1 polls answer busy, and the poll D cycles after the first answers done.
- R7: Opcode 1 on number B, with delay D from the register at bits 3:0, drives `fiq_n` low after the clock edge that lies D edges after the edge ending the command's first cycle. D = 0 drives it low at that first edge.
- R8: Opcode 2 on number B does the same for `irq_n`, with an independent counter.
- R9: Opcode 3 drives `fiq_n` high and opcode 4 drives `irq_n` high at the next edge. Each also cancels any pending schedule for its line.
- R10: A new schedule command for a line replaces the pending one. The line then follows only the newer delay.
- R11: Opcode 5 writes the value of the free-running cycle counter into the register at bits 3:0. Two captures issued N cycles apart differ by N.
- R12: Response codes are 00 done, 01 busy, 10 reject and 11 next-word. With `cmd_valid` low the response is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_first | input | 1 | First cycle of the presented command |
| cp_num | input | 4 | Coprocessor number addressed |
| cmd_kind | input | 3 | 0 move-to-core, 1 move-from-core, 2 load beat, 3 store beat, 4 data operation |
| cmd_instr | input | 32 | Instruction word carrying the index, opcode and long fields |
| wr_data | input | DATA_W | Data for a move-from-core or a load beat |
| rd_data | output | DATA_W | Register value for a move-to-core or a store beat |
| resp | output | 2 | Response code |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The timed functions are swept over delays 0 to 6. The zero case separates the immediate path from the counted path, and the non-zero cases expose off-by-one errors in the busy count and in the edge where each line falls. Move and load patterns use a different value in each of the sixteen registers, so index-field mix-ups and wrong cross-number sharing show as wrong data. Opcode sweeps on both numbers, foreign numbers and unused kinds separate accepted from rejected commands. After each rejection the lines and registers are observed to show that it had no effect. Back-to-back schedules, a clear of a pending schedule, and timestamp pairs with gaps of several lengths check replacement, cancellation and counter arithmetic.

// File: rtl/tcop_pkg.sv
package tcop_pkg;

   typedef enum logic [1:0] {
      RSP_DONE   = 2'b00,
      RSP_BUSY   = 2'b01,
      RSP_REJECT = 2'b10,
      RSP_NEXT   = 2'b11
   } rsp_e;

   typedef enum logic [2:0] {
      K_RD    = 3'd0,
      K_WR    = 3'd1,
      K_LOAD  = 3'd2,
      K_STORE = 3'd3,
      K_OP    = 3'd4
   } kind_e;

   localparam int IDX_W = 4;
   localparam int NREG  = 16;

   localparam logic [3:0] OP_WAIT     = 4'd0;
   localparam logic [3:0] OP_FAST_SET = 4'd1;
   localparam logic [3:0] OP_NORM_SET = 4'd2;
   localparam logic [3:0] OP_FAST_CLR = 4'd3;
   localparam logic [3:0] OP_NORM_CLR = 4'd4;
   localparam logic [3:0] OP_STAMP    = 4'd5;

endpackage

// File: rtl/tcop_regbank.sv
module tcop_regbank #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_b
);

   logic [DATA_W-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/tcop_timer.sv
module tcop_timer #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] dly_in,
   output logic [DATA_W-1:0] cyc_o,
   output logic              wait_over
);

   logic [DATA_W-1:0] cyc_q;
   logic [DATA_W-1:0] start_q;
   logic [DATA_W-1:0] dly_q;
   logic [DATA_W-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q   <= '0;
         start_q <= '0;
         dly_q   <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
         if (start) begin
            start_q <= cyc_q;
            dly_q   <= dly_in;
         end
      end
   end

   // wrap-safe distance from the start stamp
   assign elapsed   = cyc_q - start_q;
   assign wait_over = (elapsed >= dly_q);
   assign cyc_o     = cyc_q;

endmodule

// File: rtl/tcop_irq_line.sv
module tcop_irq_line #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arm,
   input  logic              clr,
   input  logic [DATA_W-1:0] dly,
   output logic              line_n
);

   logic [DATA_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         line_n <= 1'b1;
      end else if (clr) begin
         cnt_q  <= '0;
         line_n <= 1'b1;
      end else if (arm) begin
         if (dly == '0) begin
            cnt_q  <= '0;
            line_n <= 1'b0;
         end else begin
            cnt_q <= dly;
         end
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == DATA_W'(1)) line_n <= 1'b0;
      end
   end

endmodule

// File: rtl/tcop_core.sv
module tcop_core
   import tcop_pkg::*;
#(
   parameter int         DATA_W     = 32,
   parameter int         LONG_BEATS = 2,
   parameter logic [3:0] CP_NUM_A   = 4'd4,
   parameter logic [3:0] CP_NUM_B   = 4'd5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic              cmd_first,
   input  logic [3:0]        cp_num,
   input  logic [2:0]        cmd_kind,
   input  logic [31:0]       cmd_instr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        resp,
   output logic              fiq_n,
   output logic              irq_n
);

   localparam int BEAT_W  = $clog2(LONG_BEATS + 1);
   localparam int N_LINES = 2;

   // elaboration checks
   if (CP_NUM_A == CP_NUM_B) begin : g_bad_num
      $error("tcop_core: the two coprocessor numbers must differ");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("tcop_core: DATA_W must be at least 8");
   end
   if (LONG_BEATS < 1) begin : g_bad_beats
      $error("tcop_core: LONG_BEATS must be at least 1");
   end

   // instruction fields
   logic [IDX_W-1:0] mv_idx, mem_idx, dly_idx;
   logic [3:0]       op;
   logic             is_long;
   logic             unused_instr;

   assign mv_idx       = cmd_instr[19:16];
   assign mem_idx      = cmd_instr[15:12];
   assign dly_idx      = cmd_instr[3:0];
   assign op           = cmd_instr[23:20];
   assign is_long      = cmd_instr[22];
   assign unused_instr = ^{cmd_instr[31:24], cmd_instr[11:4]};

   logic is_a, is_b, mine;
   assign is_a = (cp_num == CP_NUM_A);
   assign is_b = (cp_num == CP_NUM_B);
   assign mine = is_a | is_b;

   // bank
   logic              we;
   logic [IDX_W-1:0]  waddr;
   logic [DATA_W-1:0] wdata;
   logic [IDX_W-1:0]  raddr_a;
   logic [DATA_W-1:0] rdata_a;
   logic [DATA_W-1:0] dly_val;

   assign raddr_a = (cmd_kind == K_STORE) ? mem_idx : mv_idx;

   tcop_regbank #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (raddr_a),
      .rdata_a (rdata_a),
      .raddr_b (dly_idx),
      .rdata_b (dly_val)
   );

   assign rd_data = rdata_a;

   // timer
   logic              wait_start;
   logic              wait_over;
   logic [DATA_W-1:0] cyc;

   tcop_timer #(.DATA_W(DATA_W)) timer_i (
      .clk       (clk),
      .rst       (rst),
      .start     (wait_start),
      .dly_in    (dly_val),
      .cyc_o     (cyc),
      .wait_over (wait_over)
   );

   // long-transfer beat tracking
   logic mem_beat;
   logic last_beat;

   assign mem_beat = cmd_valid && is_a && ((cmd_kind == K_LOAD) || (cmd_kind == K_STORE));

   if (LONG_BEATS > 1) begin : g_multi_beat
      logic [BEAT_W-1:0] beat_q;
      logic [BEAT_W-1:0] beat_cur;
      assign beat_cur  = cmd_first ? '0 : beat_q;
      assign last_beat = (beat_cur >= BEAT_W'(LONG_BEATS - 1));
      always_ff @(posedge clk) begin
         if (rst)           beat_q <= '0;
         else if (mem_beat) beat_q <= last_beat ? beat_cur : beat_cur + 1'b1;
      end
   end else begin : g_single_beat
      assign last_beat = 1'b1;
   end

   // command decode
   logic [N_LINES-1:0] arm, clr;
   logic               op_ok;

   assign op_ok = is_a ? (op == OP_WAIT) : (op <= OP_STAMP);

   always_comb begin
      resp       = RSP_DONE;
      we         = 1'b0;
      waddr      = mv_idx;
      wdata      = wr_data;
      wait_start = 1'b0;
      arm        = '0;
      clr        = '0;
      if (cmd_valid) begin
         if (!mine) begin
            resp = RSP_REJECT;
         end else begin
            case (cmd_kind)
               K_RD: resp = RSP_DONE;
               K_WR: begin
                  we   = 1'b1;
                  resp = RSP_DONE;
               end
               K_LOAD, K_STORE: begin
                  if (!is_a) begin
                     resp = RSP_REJECT;
                  end else begin
                     if (cmd_kind == K_LOAD) begin
                        we    = 1'b1;
                        waddr = mem_idx;
                     end
                     resp = (is_long && !last_beat) ? RSP_NEXT : RSP_DONE;
                  end
               end
               K_OP: begin
                  if (!op_ok) begin
                     resp = RSP_REJECT;
                  end else begin
                     case (op)
                        OP_WAIT: begin
                           if (cmd_first) begin
                              wait_start = 1'b1;
                              resp = (dly_val == '0) ? RSP_DONE : RSP_BUSY;
                           end else begin
                              resp = wait_over ? RSP_DONE : RSP_BUSY;
                           end
                        end
                        OP_FAST_SET: arm[0] = cmd_first;
                        OP_NORM_SET: arm[1] = cmd_first;
                        OP_FAST_CLR: clr[0] = cmd_first;
                        OP_NORM_CLR: clr[1] = cmd_first;
                        OP_STAMP: begin
                           we    = cmd_first;
                           waddr = dly_idx;
                           wdata = cyc;
                        end
                        default: resp = RSP_REJECT;
                     endcase
                  end
               end
               default: resp = RSP_REJECT;
            endcase
         end
      end
   end

   // interrupt lines: index 0 fast, index 1 normal
   logic [N_LINES-1:0] line_n;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      tcop_irq_line #(.DATA_W(DATA_W)) line_i (
         .clk    (clk),
         .rst    (rst),
         .arm    (arm[g]),
         .clr    (clr[g]),
         .dly    (dly_val),
         .line_n (line_n[g])
      );
   end

   assign fiq_n = line_n[0];
   assign irq_n = line_n[1];

endmodule

// File: rtl/tcop_chk.sv
module tcop_chk #(
   parameter int         DATA_W   = 32,
   parameter logic [3:0] CP_NUM_A = 4'd4,
   parameter logic [3:0] CP_NUM_B = 4'd5
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic              cmd_first,
   input logic [3:0]        cp_num,
   input logic [2:0]        cmd_kind,
   input logic [31:0]       cmd_instr,
   input logic [DATA_W-1:0] dly_val,
   input logic [1:0]        resp,
   input logic              fiq_n,
   input logic              irq_n
);

   logic b_op_first;
   assign b_op_first = cmd_valid && cmd_first && (cmd_kind == 3'd4) && (cp_num == CP_NUM_B);

   assert_lines_high_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (fiq_n && irq_n));

   assert_foreign_reject_R5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cp_num != CP_NUM_A) && (cp_num != CP_NUM_B)) |-> (resp == 2'b10));

   assert_next_only_mem_R4: assert property (@(posedge clk) disable iff (rst)
      (resp == 2'b11) |-> (cmd_valid && ((cmd_kind == 3'd2) || (cmd_kind == 3'd3))));

   assert_fast_now_R7: assert property (@(posedge clk) disable iff (rst)
      (b_op_first && (cmd_instr[23:20] == 4'd1) && (dly_val == '0)) |=> !fiq_n);

   assert_norm_now_R8: assert property (@(posedge clk) disable iff (rst)
      (b_op_first && (cmd_instr[23:20] == 4'd2) && (dly_val == '0)) |=> !irq_n);

   assert_fast_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (b_op_first && (cmd_instr[23:20] == 4'd3)) |=> fiq_n);

   assert_norm_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (b_op_first && (cmd_instr[23:20] == 4'd4)) |=> irq_n);

   assert_idle_done_R12: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> (resp == 2'b00));

endmodule

bind tcop_core tcop_chk #(
   .DATA_W   (DATA_W),
   .CP_NUM_A (CP_NUM_A),
   .CP_NUM_B (CP_NUM_B)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .cmd_valid (cmd_valid),
   .cmd_first (cmd_first),
   .cp_num    (cp_num),
   .cmd_kind  (cmd_kind),
   .cmd_instr (cmd_instr),
   .dly_val   (dly_val),
   .resp      (resp),
   .fiq_n     (fiq_n),
   .irq_n     (irq_n)
);

// File: tb/tcop_core_tb_top.sv
module tcop_core_tb_top;

   localparam int         DW = 32;
   localparam int         LB = 2;
   localparam logic [3:0] CA = 4'd4;
   localparam logic [3:0] CB = 4'd5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic          cmd_first = 1'b0;
   logic [3:0]    cp_num = 4'd0;
   logic [2:0]    cmd_kind = 3'd0;
   logic [31:0]   cmd_instr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    resp;
   logic          fiq_n, irq_n;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   tcop_core #(.DATA_W(DW), .LONG_BEATS(LB), .CP_NUM_A(CA), .CP_NUM_B(CB)) dut_i (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_first(cmd_first),
      .cp_num(cp_num), .cmd_kind(cmd_kind), .cmd_instr(cmd_instr),
      .wr_data(wr_data), .rd_data(rd_data), .resp(resp),
      .fiq_n(fiq_n), .irq_n(irq_n)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ins(input int op, input int crn, input int crd,
                                       input int crm, input bit lng);
      logic [31:0] v = '0;
      v[23:20] = op[3:0];
      v[19:16] = crn[3:0];
      v[15:12] = crd[3:0];
      v[3:0]   = crm[3:0];
      if (lng) v[22] = 1'b1;
      return v;
   endfunction

   // present a command at the falling edge, sample just after
   task automatic cmd(input logic [3:0] cp, input logic [2:0] k, input logic [31:0] ir,
                      input logic [DW-1:0] wd, input bit first,
                      output logic [1:0] r, output logic [DW-1:0] rd);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_first = first; cp_num = cp; cmd_kind = k;
      cmd_instr = ir; wr_data = wd;
      #1;
      r  = resp;
      rd = rd_data;
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0; cmd_first = 1'b0;
      #1;
   endtask

   task automatic wr_reg(input int idx, input logic [DW-1:0] v);
      logic [1:0] r; logic [DW-1:0] d;
      cmd(CA, 3'd1, ins(0, idx, 0, 0, 0), v, 1'b1, r, d);
   endtask

   task automatic rd_reg(input int idx, output logic [DW-1:0] v);
      logic [1:0] r;
      cmd(CB, 3'd0, ins(0, idx, 0, 0, 0), '0, 1'b1, r, v);
   endtask

   // issue a schedule and count falling edges until the line goes low
   task automatic time_line(input int op, input int idx, input bit fast, output int k);
      logic [1:0] r; logic [DW-1:0] d;
      cmd(CB, 3'd4, ins(op, 0, 0, idx, 0), '0, 1'b1, r, d);
      k = 0;
      for (int i = 0; i < 40; i++) begin
         idle();
         k++;
         if ((fast ? fiq_n : irq_n) == 1'b0) break;
      end
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [1:0] r;
      logic [DW-1:0] d, v3, v4;
      int k, nb;

      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;

      // R1 reset state, R12 idle response
      check(fiq_n && irq_n, "R1 lines high", {fiq_n, irq_n}, 2'b11);
      check(resp == 2'b00, "R12 idle done", resp, 0);
      for (int i = 0; i < 16; i++) begin
         rd_reg(i, d);
         check(d == '0, "R1 bank cleared", d, 0);
      end

      // R2 write on A, read on B, per-register pattern
      for (int i = 0; i < 16; i++) wr_reg(i, 32'hA500_0000 ^ (32'h0101_0101 * i));
      for (int i = 0; i < 16; i++) begin
         rd_reg(i, d);
         check(d == (32'hA500_0000 ^ (32'h0101_0101 * i)), "R2 shared bank", d,
               32'hA500_0000 ^ (32'h0101_0101 * i));
      end
      cmd(CB, 3'd1, ins(0, 7, 0, 0, 0), 32'h1234_5678, 1'b1, r, d);
      cmd(CA, 3'd0, ins(0, 7, 0, 0, 0), '0, 1'b1, r, d);
      check(d == 32'h1234_5678 && r == 2'b00, "R2 B write A read", d, 32'h1234_5678);

      // R3 short load and store on A
      cmd(CA, 3'd2, ins(0, 0, 9, 0, 0), 32'hCAFE_0009, 1'b1, r, d);
      check(r == 2'b00, "R3 short load done", r, 0);
      cmd(CA, 3'd3, ins(0, 0, 9, 0, 0), '0, 1'b1, r, d);
      check(d == 32'hCAFE_0009 && r == 2'b00, "R3 store data", d, 32'hCAFE_0009);
      // R3 load and store on B rejected, bank unchanged
      cmd(CB, 3'd2, ins(0, 0, 9, 0, 0), 32'hDEAD_BEEF, 1'b1, r, d);
      check(r == 2'b10, "R3 load on B rejected", r, 2);
      cmd(CB, 3'd3, ins(0, 0, 9, 0, 0), '0, 1'b1, r, d);
      check(r == 2'b10, "R3 store on B rejected", r, 2);
      rd_reg(9, d);
      check(d == 32'hCAFE_0009, "R3 bank unchanged", d, 32'hCAFE_0009);

      // R4 long load: beats 0..LB-2 next, last done, last word kept
      for (int b = 0; b < LB; b++) begin
         cmd(CA, 3'd2, ins(0, 0, 10, 0, 1), 32'h5000_0000 + b, b == 0, r, d);
         check(r == ((b == LB - 1) ? 2'b00 : 2'b11), "R4 long load resp", r, (b == LB - 1) ? 0 : 3);
      end
      rd_reg(10, d);
      check(d == 32'h5000_0000 + LB - 1, "R4 last word kept", d, 32'h5000_0000 + LB - 1);
      for (int b = 0; b < LB; b++) begin
         cmd(CA, 3'd3, ins(0, 0, 10, 0, 1), '0, b == 0, r, d);
         check(r == ((b == LB - 1) ? 2'b00 : 2'b11) && d == 32'h5000_0000 + LB - 1,
               "R4 long store", {r, d}, {((b == LB - 1) ? 2'b00 : 2'b11), 32'h5000_0000 + LB - 1});
      end
      idle();

      // R5 opcode acceptance sweep, register 0 holds zero delay
      wr_reg(0, '0);
      for (int op = 0; op < 16; op++) begin
         cmd(CA, 3'd4, ins(op, 0, 0, 0, 0), '0, 1'b1, r, d);
         check(r == ((op == 0) ? 2'b00 : 2'b10), "R5 number A opcode", r, (op == 0) ? 0 : 2);
      end
      for (int op = 6; op < 16; op++) begin
         cmd(CB, 3'd4, ins(op, 0, 0, 0, 0), '0, 1'b1, r, d);
         check(r == 2'b10, "R5 number B high opcode", r, 2);
      end
      for (int kk = 5; kk < 8; kk++) begin
         cmd(CA, 3'(kk), ins(0, 0, 0, 0, 0), '0, 1'b1, r, d);
         check(r == 2'b10, "R5 unused kind", r, 2);
      end
      cmd(4'd9, 3'd0, ins(0, 0, 0, 0, 0), '0, 1'b1, r, d);
      check(r == 2'b10, "R5 foreign number", r, 2);
      // rejected schedule on A leaves lines high
      cmd(CA, 3'd4, ins(1, 0, 0, 0, 0), '0, 1'b1, r, d);
      cmd(4'd9, 3'd4, ins(2, 0, 0, 0, 0), '0, 1'b1, r, d);
      for (int i = 0; i < 4; i++) idle();
      check(fiq_n && irq_n, "R5 rejected no effect", {fiq_n, irq_n}, 2'b11);

      // R6 busy-wait sweep on both numbers
      for (int dl = 0; dl <= 6; dl++) begin
         for (int s = 0; s < 2; s++) begin
            wr_reg(2, DW'(dl));
            cmd(s ? CB : CA, 3'd4, ins(0, 0, 0, 2, 0), '0, 1'b1, r, d);
            nb = 0;
            while (r == 2'b01 && nb < 100) begin
               nb++;
               cmd(s ? CB : CA, 3'd4, ins(0, 0, 0, 2, 0), '0, 1'b0, r, d);
            end
            check(nb == dl && r == 2'b00, "R6 busy count", nb, dl);
         end
      end
      idle();

      // R7 / R8 schedule sweep, R9 clear
      for (int dl = 0; dl <= 5; dl++) begin
         wr_reg(3, DW'(dl));
         time_line(1, 3, 1'b1, k);
         check(k == dl + 1, "R7 fast delay", k, dl + 1);
         check(irq_n == 1'b1, "R8 normal untouched", irq_n, 1);
         cmd(CB, 3'd4, ins(3, 0, 0, 0, 0), '0, 1'b1, r, d);
         idle();
         check(fiq_n == 1'b1, "R9 fast clear", fiq_n, 1);
         time_line(2, 3, 1'b0, k);
         check(k == dl + 1, "R8 normal delay", k, dl + 1);
         check(fiq_n == 1'b1, "R7 fast untouched", fiq_n, 1);
         cmd(CB, 3'd4, ins(4, 0, 0, 0, 0), '0, 1'b1, r, d);
         idle();
         check(irq_n == 1'b1, "R9 normal clear", irq_n, 1);
      end

      // R9 clear cancels a pending schedule
      wr_reg(4, DW'(4));
      cmd(CB, 3'd4, ins(1, 0, 0, 4, 0), '0, 1'b1, r, d);
      cmd(CB, 3'd4, ins(3, 0, 0, 0, 0), '0, 1'b1, r, d);
      k = 0;
      for (int i = 0; i < 10; i++) begin
         idle();
         if (!fiq_n) k++;
      end
      check(k == 0, "R9 pending cancelled", k, 0);

      // R10 replacement: long delay then short delay
      wr_reg(5, DW'(12));
      wr_reg(6, DW'(3));
      cmd(CB, 3'd4, ins(2, 0, 0, 5, 0), '0, 1'b1, r, d);
      time_line(2, 6, 1'b0, k);
      check(k == 4, "R10 newer delay wins", k, 4);
      cmd(CB, 3'd4, ins(4, 0, 0, 0, 0), '0, 1'b1, r, d);
      wr_reg(5, DW'(2));
      wr_reg(6, DW'(9));
      cmd(CB, 3'd4, ins(1, 0, 0, 5, 0), '0, 1'b1, r, d);
      time_line(1, 6, 1'b1, k);
      check(k == 10, "R10 longer replaces shorter", k, 10);
      cmd(CB, 3'd4, ins(3, 0, 0, 0, 0), '0, 1'b1, r, d);
      idle();

      // R11 timestamp differences
      for (int gap = 0; gap < 6; gap++) begin
         cmd(CB, 3'd4, ins(5, 0, 0, 11, 0), '0, 1'b1, r, d);
         check(r == 2'b00, "R11 stamp done", r, 0);
         for (int i = 0; i < gap; i++) idle();
         cmd(CB, 3'd4, ins(5, 0, 0, 12, 0), '0, 1'b1, r, d);
         rd_reg(11, v3);
         rd_reg(12, v4);
         check(v4 - v3 == DW'(gap + 1), "R11 stamp difference", v4 - v3, gap + 1);
      end

      idle();
      check(resp == 2'b00, "R12 idle after run", resp, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule